// File: doc/BRIEF.md
# Size-Aware Status Flags and Protected Stack Pointer

This block keeps a processor's condition flags and its stack pointer. When an ALU operation completes, the block receives the full 64-bit result, the operand size (8, 16, 32 or 64 bits), and one carry-out bit and one signed-overflow bit for each size boundary. It derives negative, zero, carry and overflow at the active size and registers them. Flag bits can also be set or cleared directly by command. These commands take precedence over an ALU update in the same cycle.

The stack pointer can be held, incremented, decremented or loaded with the value of the X register. A protection flag in the status byte stops a push or pop from wrapping past either end of the 64-bit range. Such a blocked move raises a one-cycle fault pulse. The status word, the interrupt-mask state and the pointer are all taken straight from registers, so each change appears on the clock edge after the command.

Top module: `flag_stack_unit`

## Requirements
- R1: Negative (bit 7) is the most significant bit of the result at the active size, and Zero (bit 1) is set when the low size bits of the result are all zero. Size code 0/1/2/3 selects 8/16/32/64 bits.
- R2: Carry (bit 0) takes the bit of `alu_carry_vec` indexed by the size code, and Overflow (bit 6) takes the bit of `alu_ovf_vec` indexed by the size code.
- R3: N, V, Z and C change only on a cycle with `alu_valid` high or on a flag command. The new values appear on `status_word` one clock after the update.
- R4: Bits 63:8 and bits 5:4 of `status_word` always read zero, whatever commands are issued.
- R5: `flag_set` and `flag_clr` (bit masks using the flag bit positions) override an ALU update to the same bit in the same cycle. When a bit is both set and cleared, the set wins.
- R6: Interrupt mask (bit 2) changes only by command. `int_mask` equals that bit, and a 1 means maskable interrupts are disabled.
- R7: After reset, `status_word` is 0x04 (only the interrupt mask set), `stack_ptr` is `SP_INIT` (default 0) and `stack_fault` is 0.
- R8: `sp_op` encodes 0 hold, 1 increment, 2 decrement, 3 load. With protection (bit 3) clear, increment and decrement wrap modulo 2^64.
- R9: With protection set, an increment at all-ones or a decrement at zero leaves `stack_ptr` unchanged.
- R10: A blocked move raises `stack_fault` for exactly the following cycle. No other operation raises it.
- R11: A load (`sp_op`=3) copies `sp_load_val` (the X register) into the pointer regardless of protection, and never faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_valid | input | 1 | ALU result present this cycle |
| alu_size | input | 2 | Operand size code (0=8,1=16,2=32,3=64 bits) |
| alu_result | input | 64 | ALU result |
| alu_carry_vec | input | 4 | Carry out at each size boundary |
| alu_ovf_vec | input | 4 | Signed overflow at each size boundary |
| flag_set | input | 8 | Flag bits to set |
| flag_clr | input | 8 | Flag bits to clear |
| sp_op | input | 2 | Stack pointer operation |
| sp_load_val | input | 64 | X register value for a pointer load |
| status_word | output | 64 | Status register (flags in low byte) |
| int_mask | output | 1 | Maskable interrupts disabled |
| stack_ptr | output | 64 | Current stack pointer |
| stack_fault | output | 1 | One-cycle pulse after a blocked move |

## Verification
An ALU flag update and an explicit set/clear command can land in the same cycle. The bench provokes this by issuing an ALU result whose zero and carry outcomes oppose the commanded bits. It then checks that the commanded values are the ones registered, and that a bit both set and cleared ends up set. A second overlap occurs when the protection flag is raised in the same cycle as a boundary push. The bench judges this by expecting that move to use the protection value held before the edge.

// File: rtl/flag_stack_pkg.sv
// Package: shared widths, flag bit positions, size and stack command encodings.
// Assumes a 64-bit word split into four power-of-two operand sizes from 8 bits up.
package flag_stack_pkg;

    localparam int WORD_W    = 64;
    localparam int FLAG_W    = 8;
    localparam int NUM_SIZES = 4;
    localparam int SIZE_W    = $clog2(NUM_SIZES);

    // Flag bit positions inside the status byte
    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_I = 2;
    localparam int FB_S = 3;
    localparam int FB_V = 6;
    localparam int FB_N = 7;

    localparam logic [FLAG_W-1:0] FLAG_USED  = 8'hCF;
    localparam logic [FLAG_W-1:0] FLAG_RESET = 8'h04;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } op_size_e;

    typedef enum logic [1:0] {
        SP_HOLD = 2'd0,
        SP_INC  = 2'd1,
        SP_DEC  = 2'd2,
        SP_LOAD = 2'd3
    } sp_cmd_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/result_flag_eval.sv
// Module: result_flag_eval
// Derives N, V, Z, C from an ALU result at the selected operand size.
// Assumes the ALU supplies carry and overflow per size boundary; purely combinational.
module result_flag_eval
    import flag_stack_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int SIZES  = NUM_SIZES
) (
    input  logic [DATA_W-1:0]        result,
    input  logic [$clog2(SIZES)-1:0] size_sel,
    input  logic [SIZES-1:0]         carry_vec,
    input  logic [SIZES-1:0]         ovf_vec,
    output alu_flags_t               flags
);

    localparam int SEL_W = $clog2(SIZES);

    logic [SIZES-1:0] lane_neg;
    logic [SIZES-1:0] lane_zero;

    // One lane per operand size: sign bit and zero test of the low bits
    for (genvar k = 0; k < SIZES; k++) begin : g_lane
        localparam int MSB = (8 << k) - 1;
        assign lane_neg[k]  = result[MSB];
        assign lane_zero[k] = ~|result[MSB:0];
    end

    // Pick the lane matching the active operand size
    always_comb begin
        flags.n = lane_neg[size_sel];
        flags.z = lane_zero[size_sel];
        flags.c = carry_vec[size_sel];
        flags.v = ovf_vec[size_sel];
    end

    logic unused_sel;
    assign unused_sel = ^{SEL_W{1'b0}};

endmodule

// File: rtl/status_flag_reg.sv
// Module: status_flag_reg
// Holds the status byte; merges an ALU flag update with set/clear commands.
// Commands override the ALU update; set beats clear; unused bits stay zero.
module status_flag_reg
    import flag_stack_pkg::*;
#(
    parameter int                FW       = FLAG_W,
    parameter logic [FW-1:0]     USED     = FLAG_USED,
    parameter logic [FW-1:0]     RST_VAL  = FLAG_RESET
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alu_valid,
    input  alu_flags_t    alu_flags,
    input  logic [FW-1:0] cmd_set,
    input  logic [FW-1:0] cmd_clr,
    output logic [FW-1:0] flags_q
);

    logic [FW-1:0] flags_d;

    // Next-state: apply ALU result flags, then commands, then mask
    always_comb begin
        flags_d = flags_q;
        if (alu_valid) begin
            flags_d[FB_N] = alu_flags.n;
            flags_d[FB_V] = alu_flags.v;
            flags_d[FB_Z] = alu_flags.z;
            flags_d[FB_C] = alu_flags.c;
        end
        flags_d = (flags_d & ~cmd_clr) | cmd_set;
        flags_d = flags_d & USED;
    end

    // Register the status byte with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= RST_VAL;
        else        flags_q <= flags_d;
    end

endmodule

// File: rtl/stack_pointer_ctl.sv
// Module: stack_pointer_ctl
// Stack pointer with hold/increment/decrement/load; saturates when protected.
// Protection is sampled from the registered flag; fault is a registered pulse.
module stack_pointer_ctl
    import flag_stack_pkg::*;
#(
    parameter int                DATA_W  = WORD_W,
    parameter logic [DATA_W-1:0] SP_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sp_cmd_e           op,
    input  logic [DATA_W-1:0] load_val,
    input  logic              protect,
    output logic [DATA_W-1:0] sp_q,
    output logic              fault_q
);

    localparam logic [DATA_W-1:0] SP_MAX = '1;
    localparam logic [DATA_W-1:0] SP_MIN = '0;
    localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);

    logic [DATA_W-1:0] sp_d;
    logic              blocked;

    // Decide the next pointer value and whether the move is blocked
    always_comb begin
        sp_d    = sp_q;
        blocked = 1'b0;
        unique case (op)
            SP_INC: begin
                if (protect && sp_q == SP_MAX) blocked = 1'b1;
                else                           sp_d    = sp_q + ONE;
            end
            SP_DEC: begin
                if (protect && sp_q == SP_MIN) blocked = 1'b1;
                else                           sp_d    = sp_q - ONE;
            end
            SP_LOAD: sp_d = load_val;
            default: sp_d = sp_q;
        endcase
    end

    // Register the pointer and the fault pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q    <= SP_INIT;
            fault_q <= 1'b0;
        end else begin
            sp_q    <= sp_d;
            fault_q <= blocked;
        end
    end

endmodule

// File: rtl/flag_stack_unit.sv
// Module: flag_stack_unit (top)
// Status flags computed at the active operand size plus a protected stack pointer.
// Assumes one ALU result per cycle at most; all outputs come from registers.
module flag_stack_unit
    import flag_stack_pkg::*;
#(
    parameter logic [63:0] SP_INIT = 64'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        alu_valid,
    input  logic [1:0]  alu_size,
    input  logic [63:0] alu_result,
    input  logic [3:0]  alu_carry_vec,
    input  logic [3:0]  alu_ovf_vec,
    input  logic [7:0]  flag_set,
    input  logic [7:0]  flag_clr,
    input  logic [1:0]  sp_op,
    input  logic [63:0] sp_load_val,
    output logic [63:0] status_word,
    output logic        int_mask,
    output logic [63:0] stack_ptr,
    output logic        stack_fault
);

    localparam int PAD_W = WORD_W - FLAG_W;

    alu_flags_t        eval_flags;
    logic [FLAG_W-1:0] flags_q;
    sp_cmd_e           sp_cmd;

    // Convert the raw command code to the enum
    always_comb sp_cmd = sp_cmd_e'(sp_op);

    result_flag_eval #(.DATA_W(WORD_W), .SIZES(NUM_SIZES)) u_eval (
        .result    (alu_result),
        .size_sel  (alu_size),
        .carry_vec (alu_carry_vec),
        .ovf_vec   (alu_ovf_vec),
        .flags     (eval_flags)
    );

    status_flag_reg #(.FW(FLAG_W), .USED(FLAG_USED), .RST_VAL(FLAG_RESET)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .alu_valid (alu_valid),
        .alu_flags (eval_flags),
        .cmd_set   (flag_set),
        .cmd_clr   (flag_clr),
        .flags_q   (flags_q)
    );

    stack_pointer_ctl #(.DATA_W(WORD_W), .SP_INIT(SP_INIT)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (sp_cmd),
        .load_val (sp_load_val),
        .protect  (flags_q[FB_S]),
        .sp_q     (stack_ptr),
        .fault_q  (stack_fault)
    );

    // Widen the flag byte into the status word
    assign status_word = {{PAD_W{1'b0}}, flags_q};
    assign int_mask    = flags_q[FB_I];

endmodule

// File: rtl/flag_stack_unit_chk.sv
// Module: flag_stack_unit_chk
// Checker bound to flag_stack_unit; relates commands to registered outputs.
module flag_stack_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  flag_set,
    input logic [7:0]  flag_clr,
    input logic [1:0]  sp_op,
    input logic [63:0] sp_load_val,
    input logic [63:0] status_word,
    input logic [63:0] stack_ptr,
    input logic        stack_fault
);

    p_unused_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[63:8] == '0) && (status_word[5:4] == 2'b00));

    p_set_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[0] |=> status_word[0]);

    p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[1] && !flag_set[1]) |=> !status_word[1]);

    p_wrap_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_word[3] && sp_op == 2'd1 && stack_ptr == '1) |=> (stack_ptr == '0));

    p_sat_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[3] && sp_op == 2'd1 && stack_ptr == '1) |=> ($stable(stack_ptr) && stack_fault));

    p_sat_bottom_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[3] && sp_op == 2'd2 && stack_ptr == '0) |=> ($stable(stack_ptr) && stack_fault));

    p_fault_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_op == 2'd0 || sp_op == 2'd3) |=> !stack_fault);

    p_load_x_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_op == 2'd3) |=> (stack_ptr == $past(sp_load_val)));

endmodule

bind flag_stack_unit flag_stack_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_set    (flag_set),
    .flag_clr    (flag_clr),
    .sp_op       (sp_op),
    .sp_load_val (sp_load_val),
    .status_word (status_word),
    .stack_ptr   (stack_ptr),
    .stack_fault (stack_fault)
);

// File: tb/test_flag_stack_unit.sv
`timescale 1ns/1ps
// Bench: vector table for size-aware flags, then directed reset/command/stack tests.
module test_flag_stack_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        alu_valid;
    logic [1:0]  alu_size;
    logic [63:0] alu_result;
    logic [3:0]  alu_carry_vec;
    logic [3:0]  alu_ovf_vec;
    logic [7:0]  flag_set;
    logic [7:0]  flag_clr;
    logic [1:0]  sp_op;
    logic [63:0] sp_load_val;
    logic [63:0] status_word;
    logic        int_mask;
    logic [63:0] stack_ptr;
    logic        stack_fault;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // 125 MHz clock
    always #4 clk = ~clk;

    flag_stack_unit i_flag_stack_unit (.*);

    typedef struct packed {
        logic [1:0]  size;
        logic [63:0] result;
        logic [3:0]  carry;
        logic [3:0]  ovf;
        logic [3:0]  nvzc;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 64'h0000_0000_0000_0100, 4'b0001, 4'b0000, 4'b0011},
        '{2'd0, 64'h0000_0000_0000_0080, 4'b0000, 4'b0001, 4'b1100},
        '{2'd1, 64'h0000_0000_0001_0000, 4'b0001, 4'b0010, 4'b0110},
        '{2'd1, 64'h0000_0000_0000_8000, 4'b0010, 4'b0000, 4'b1001},
        '{2'd2, 64'h0000_0001_0000_0000, 4'b0100, 4'b0000, 4'b0011},
        '{2'd2, 64'h0000_0000_8000_0000, 4'b0000, 4'b0100, 4'b1100},
        '{2'd3, 64'h8000_0000_0000_0000, 4'b1000, 4'b1000, 4'b1101},
        '{2'd3, 64'h0000_0000_0000_0000, 4'b0111, 4'b0111, 4'b0010},
        '{2'd2, 64'hFFFF_FFFF_0000_0001, 4'b0000, 4'b0000, 4'b0000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        alu_valid = 1'b0; alu_size = 2'd0; alu_result = '0;
        alu_carry_vec = '0; alu_ovf_vec = '0;
        flag_set = '0; flag_clr = '0; sp_op = 2'd0; sp_load_val = '0;
    endtask

    // Let one rising edge pass, return at the following falling edge with inputs idle
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R7 reset state; R6 mask set at reset
        check("R7 status", status_word, 64'h4);
        check("R7 sp", stack_ptr, 64'h0);
        check("R7 fault", {63'd0, stack_fault}, 64'h0);
        check("R6 int_mask reset", {63'd0, int_mask}, 64'h1);

        // R1 R2 R3 vector walk: expected byte = {N,V,0,0,S=0,I=1,Z,C}
        for (int i = 0; i < NV; i++) begin
            alu_valid = 1'b1; alu_size = VECS[i].size; alu_result = VECS[i].result;
            alu_carry_vec = VECS[i].carry; alu_ovf_vec = VECS[i].ovf;
            tick();
            check($sformatf("R1/R2 vector %0d", i), status_word,
                  {56'd0, VECS[i].nvzc[3], VECS[i].nvzc[2], 4'b0001, VECS[i].nvzc[1], VECS[i].nvzc[0]});
        end

        // R3 no alu_valid: flags hold despite a zero result on the bus
        alu_result = '0; alu_carry_vec = 4'hF;
        tick();
        check("R3 hold without valid", status_word, 64'h04);

        // R5 commands override ALU: result zero with carry, clear Z and C, set N
        alu_valid = 1'b1; alu_size = 2'd0; alu_result = '0; alu_carry_vec = 4'b0001;
        flag_clr = 8'h03; flag_set = 8'h80;
        tick();
        check("R5 priority over ALU", status_word, 64'h84);

        // R5 set wins over clear on the same bit
        flag_set = 8'h01; flag_clr = 8'h81;
        tick();
        check("R5 set beats clear", status_word, 64'h05);

        // R4 unused bits ignored
        flag_set = 8'h30;
        tick();
        check("R4 unused bits", status_word, 64'h05);

        // R6 interrupt mask clear and set by command
        flag_clr = 8'h04;
        tick();
        check("R6 mask cleared", {63'd0, int_mask}, 64'h0);
        flag_set = 8'h04;
        tick();
        check("R6 mask set", {63'd0, int_mask}, 64'h1);

        // R8 wrap without protection
        sp_op = 2'd2;
        tick();
        check("R8 dec wraps", stack_ptr, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R10 no fault on wrap", {63'd0, stack_fault}, 64'h0);
        sp_op = 2'd1;
        tick();
        check("R8 inc wraps", stack_ptr, 64'h0);

        // R9 protection set alongside a decrement at zero: old S used, so wraps
        flag_set = 8'h08; sp_op = 2'd2;
        tick();
        check("R9 S sampled before edge", stack_ptr, 64'hFFFF_FFFF_FFFF_FFFF);
        // R9 now protected: increment at max is blocked
        sp_op = 2'd1;
        tick();
        check("R9 inc saturates", stack_ptr, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R10 fault raised", {63'd0, stack_fault}, 64'h1);
        tick();
        check("R10 fault one cycle", {63'd0, stack_fault}, 64'h0);

        // R11 load from X while protected
        sp_op = 2'd3; sp_load_val = 64'h0;
        tick();
        check("R11 load", stack_ptr, 64'h0);
        check("R11 no fault", {63'd0, stack_fault}, 64'h0);
        sp_op = 2'd2;
        tick();
        check("R9 dec saturates", stack_ptr, 64'h0);
        check("R10 fault on dec", {63'd0, stack_fault}, 64'h1);
        sp_op = 2'd3; sp_load_val = 64'h1234_5678_9ABC_DEF0;
        tick();
        check("R11 load value", stack_ptr, 64'h1234_5678_9ABC_DEF0);
        sp_op = 2'd2;
        tick();
        check("R8 plain dec", stack_ptr, 64'h1234_5678_9ABC_DEEF);
        check("R10 no fault plain", {63'd0, stack_fault}, 64'h0);

        // R7 reset again restores everything
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        check("R7 status after reset", status_word, 64'h4);
        check("R7 sp after reset", stack_ptr, 64'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule